// File: doc/BRIEF.md
# I2C Master START Generator with Collision Detection

This block produces the opening START condition of an I2C transaction for one bus master and watches the bus while it does so. A software write of the start-enable bit launches the sequence. The block only ever pulls SDA and SCL low, through output-enable signals toward open-drain pads, and it reads both lines back through a two-flop synchronizer.

Two hold intervals set the timing. Both are measured by a down-counter loaded from a 7-bit reload value. Collision rules depend on the phase. A line found low at launch aborts the sequence. SCL falling while SDA is still released in the first interval also aborts it, because another master is taken to be sending a one. SDA falling in the first interval is taken as an early START and shortens the sequence. SCL activity in the second interval is tolerated. At completion the block holds both lines low for one cycle, pulses done and hands the bus on. The interrupt and collision flags are sticky until software clears them.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, sda_oe, scl_oe, start_en, busy, start_done, bus_coll and irq_flag are all 0.
- R2: A start_req pulse while busy is 0 sets start_en and busy on the next clock edge. A start_req while busy is 1 has no effect on the sequence timing.
- R3: If the synchronized SDA or SCL is 0 in the check cycle (the cycle after acceptance), the block sets bus_coll, clears start_en, returns to idle (busy 0) and never asserts either output enable.
- R4: In the check-cycle abort, irq_flag is set only when SDA is 0 and SCL is 1. It stays 0 when SCL is 0.
- R5: Let E be the reload value, or 1 when the reload value is 0. With quiet lines, sda_oe rises 1+E cycles after the acceptance edge and start_done 1+2E cycles after it.
- R6: SCL seen low while SDA is seen high during the first interval sets bus_coll and aborts to idle with no output enable and no irq_flag. The effect appears 3 cycles after the line change, because of the synchronizer and the decision register.
- R7: SDA seen low during the first interval is not a collision. sda_oe rises 3 cycles after the line change, and start_done follows E cycles later.
- R8: SCL going low during the second interval causes no collision and does not change the start_done time.
- R9: start_done is a one-cycle pulse with both sda_oe and scl_oe at 1. At the same edge irq_flag is set and start_en is cleared. In the next cycle both enables are released and busy is 0.
- R10: bus_coll and irq_flag stay set until clr_coll or clr_irq respectively. When a set and a clear fall in the same cycle, the set wins.
- R11: scl_oe is never 1 unless sda_oe is 1, and the lines are never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Software write of the start-enable bit (one-cycle pulse) |
| reload | input | 7 | Baud-rate reload value for both hold intervals |
| clr_irq | input | 1 | Software clear of irq_flag |
| clr_coll | input | 1 | Software clear of bus_coll |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| start_en | output | 1 | Start-enable bit as seen by software |
| busy | output | 1 | Sequence in progress |
| start_done | output | 1 | START completed (one-cycle pulse) |
| bus_coll | output | 1 | Sticky bus-collision flag |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Two functions can meet in one cycle: a software clear of a sticky flag, and the hardware event that sets the same flag. The bench provokes this by holding SDA low before launch and asserting clr_coll and clr_irq exactly in the check cycle. Both flags must read 1 afterwards. A later clear with no pending event must return them to 0. A second overlap is an SDA fall that lands on the last cycle of the first count. Early assertion and expiry then coincide, and the bench judges the case by the exact sda_oe and start_done cycles that its timing functions predict.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int RELOAD_W_DEF = 7;
  localparam int SYNC_STAGES  = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_HOLD1 = 3'd2,
    ST_HOLD2 = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  // Sticky flag update: a set in the same cycle beats a clear.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = i2cs_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  // One synchronizer chain per line; idle bus level is high.
  for (genvar b = 0; b < W; b++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2cs_holdcnt.sv
module i2cs_holdcnt #(
  parameter int W = i2cs_pkg::RELOAD_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         expired
);

  // An interval lasts max(reload,1) cycles: the count is loaded with one
  // less than that, and the last cycle is the one where the count is zero.
  function automatic logic [W-1:0] first_count(input logic [W-1:0] r);
    return (r == '0) ? '0 : r - 1'b1;
  endfunction

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= first_count(reload);
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic clr_irq,
  input  logic clr_coll,
  input  logic sda_s,
  input  logic scl_s,
  input  logic cnt_expired,
  output logic cnt_load,
  output logic cnt_run,
  output logic sda_oe,
  output logic scl_oe,
  output logic start_en,
  output logic busy,
  output logic start_done,
  output logic bus_coll,
  output logic irq_flag,
  output logic ev_accept,
  output logic ev_coll,
  output logic ev_early,
  output logic ev_finish
);

  seq_state_t state_q, state_d;
  logic en_q, coll_q, irq_q;

  // Named events, each a decision of one phase.
  logic pre_fail, pre_bus_start, h1_coll, h1_expire, to_hold2;

  assign ev_accept     = (state_q == ST_IDLE) && start_req;
  assign pre_fail      = (state_q == ST_CHECK) && (!sda_s || !scl_s);
  assign pre_bus_start = (state_q == ST_CHECK) && !sda_s && scl_s;
  assign h1_coll       = (state_q == ST_HOLD1) && sda_s && !scl_s;
  assign ev_early      = (state_q == ST_HOLD1) && !sda_s;
  assign h1_expire     = (state_q == ST_HOLD1) && sda_s && scl_s && cnt_expired;
  assign to_hold2      = ev_early || h1_expire;
  assign ev_coll       = pre_fail || h1_coll;
  assign ev_finish     = (state_q == ST_HOLD2) && cnt_expired;

  assign cnt_load = ((state_q == ST_CHECK) && !pre_fail) || to_hold2;
  assign cnt_run  = (state_q == ST_HOLD1) || (state_q == ST_HOLD2);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ev_accept) state_d = ST_CHECK;
      ST_CHECK: state_d = pre_fail ? ST_IDLE : ST_HOLD1;
      ST_HOLD1: begin
        if (h1_coll)       state_d = ST_IDLE;
        else if (to_hold2) state_d = ST_HOLD2;
      end
      ST_HOLD2: if (ev_finish) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      coll_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_accept)                en_q <= 1'b1;
      else if (ev_coll || ev_finish) en_q <= 1'b0;
      coll_q <= sticky_next(coll_q, ev_coll, clr_coll);
      irq_q  <= sticky_next(irq_q, pre_bus_start || ev_finish, clr_irq);
    end
  end

  assign sda_oe     = (state_q == ST_HOLD2) || (state_q == ST_DONE);
  assign scl_oe     = (state_q == ST_DONE);
  assign start_done = (state_q == ST_DONE);
  assign busy       = (state_q != ST_IDLE);
  assign start_en   = en_q;
  assign bus_coll   = coll_q;
  assign irq_flag   = irq_q;

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
  parameter int RELOAD_W = i2cs_pkg::RELOAD_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                clr_irq,
  input  logic                clr_coll,
  input  logic                sda_in,
  input  logic                scl_in,
  output logic                sda_oe,
  output logic                scl_oe,
  output logic                start_en,
  output logic                busy,
  output logic                start_done,
  output logic                bus_coll,
  output logic                irq_flag
);

  localparam int LINES = 2;

  logic [LINES-1:0] line_sync;
  logic sda_s, scl_s;
  logic cnt_load, cnt_run, cnt_expired;
  logic ev_accept, ev_coll, ev_early, ev_finish;

  i2cs_sync #(.W(LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({scl_in, sda_in}),
    .q_sync  (line_sync)
  );

  assign sda_s = line_sync[0];
  assign scl_s = line_sync[1];

  i2cs_holdcnt #(.W(RELOAD_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .run     (cnt_run),
    .reload  (reload),
    .expired (cnt_expired)
  );

  i2cs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .clr_irq     (clr_irq),
    .clr_coll    (clr_coll),
    .sda_s       (sda_s),
    .scl_s       (scl_s),
    .cnt_expired (cnt_expired),
    .cnt_load    (cnt_load),
    .cnt_run     (cnt_run),
    .sda_oe      (sda_oe),
    .scl_oe      (scl_oe),
    .start_en    (start_en),
    .busy        (busy),
    .start_done  (start_done),
    .bus_coll    (bus_coll),
    .irq_flag    (irq_flag),
    .ev_accept   (ev_accept),
    .ev_coll     (ev_coll),
    .ev_early    (ev_early),
    .ev_finish   (ev_finish)
  );

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic clr_coll,
  input logic sda_oe,
  input logic scl_oe,
  input logic start_en,
  input logic busy,
  input logic start_done,
  input logic bus_coll,
  input logic irq_flag,
  input logic ev_accept,
  input logic ev_coll,
  input logic ev_early,
  input logic ev_finish
);

  // R11
  scl_needs_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> sda_oe);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sda_oe && !scl_oe && !start_done));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (busy && start_en));

  // R3
  coll_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_coll |=> (bus_coll && !busy && !start_en && !sda_oe));

  // R7
  early_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_early |=> (sda_oe && !scl_oe && !$rose(bus_coll)));

  // R9
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (start_done && irq_flag && !start_en));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |=> (!busy && !sda_oe && !scl_oe));

  // R10
  coll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_coll && !clr_coll) |=> bus_coll);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_coll && clr_coll) |=> bus_coll);

  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !ev_coll && !ev_finish && !start_done) |=> start_en);

endmodule

bind i2c_start_gen i2cs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_req  (start_req),
  .clr_coll   (clr_coll),
  .sda_oe     (sda_oe),
  .scl_oe     (scl_oe),
  .start_en   (start_en),
  .busy       (busy),
  .start_done (start_done),
  .bus_coll   (bus_coll),
  .irq_flag   (irq_flag),
  .ev_accept  (ev_accept),
  .ev_coll    (ev_coll),
  .ev_early   (ev_early),
  .ev_finish  (ev_finish)
);

// File: tb/i2c_start_gen_bench.sv
module i2c_start_gen_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic [6:0] reload = '0;
  logic clr_irq = 1'b0;
  logic clr_coll = 1'b0;
  logic ext_sda_low = 1'b0;
  logic ext_scl_low = 1'b0;
  logic sda_oe, scl_oe, start_en, busy, start_done, bus_coll, irq_flag;
  logic sda_line, scl_line;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // Open-drain bus: released lines float high.
  assign sda_line = ~(sda_oe | ext_sda_low);
  assign scl_line = ~(scl_oe | ext_scl_low);

  i2c_start_gen u_i2c_start_gen (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .reload(reload),
    .clr_irq(clr_irq), .clr_coll(clr_coll), .sda_in(sda_line),
    .scl_in(scl_line), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .start_en(start_en), .busy(busy), .start_done(start_done),
    .bus_coll(bus_coll), .irq_flag(irq_flag)
  );

  task automatic check(input bit ok, input string req, input int act,
                       input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_of(input logic [6:0] r);
    return (r == 0) ? 1 : int'(r);
  endfunction

  // Cycle index (negedges after the accept edge) where an event is seen.
  function automatic int quiet_sda_at(input int e);  return 1 + e;     endfunction
  function automatic int quiet_done_at(input int e); return 1 + 2 * e; endfunction
  function automatic int line_effect_at(input int inj); return inj + 3; endfunction

  // sc: 0 quiet, 1 SDA low before, 2 SCL low before, 3 both low before,
  //     4 SCL low in first interval, 5 SDA low in first interval,
  //     6 SCL low in second interval
  task automatic run_trial(input int sc, input logic [6:0] r, input int inj);
    int e = eff_of(r);
    int sda_n = -1, done_n = -1, coll_n = -1;
    int exp_sda, exp_done, exp_coll, exp_irq;
    reload = r;
    ext_sda_low = (sc == 1 || sc == 3);
    ext_scl_low = (sc == 2 || sc == 3);
    repeat (4) @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    // R2: accepted at the edge just passed
    check(start_en && busy, "R2 accept", {start_en, busy}, 3);
    for (int n = 1; n <= 2 * e + 12; n++) begin
      @(negedge clk);
      if (sda_oe && sda_n < 0) sda_n = n;
      if (start_done && done_n < 0) begin
        done_n = n;
        // R9 / R11: both lines pulled in the done cycle
        check(sda_oe && scl_oe, "R9 done drives", {sda_oe, scl_oe}, 3);
      end
      if (scl_oe && !sda_oe) check(1'b0, "R11 scl without sda", 1, 0);
      if (bus_coll && coll_n < 0) coll_n = n;
      start_req = (sc == 0 && n == 2);
      if (n == inj && sc == 4) ext_scl_low = 1'b1;
      if (n == inj && sc == 5) ext_sda_low = 1'b1;
      if (n == inj && sc == 6) ext_scl_low = 1'b1;
    end
    start_req = 1'b0;
    case (sc)
      0, 6: begin exp_sda = quiet_sda_at(e); exp_done = quiet_done_at(e);
                  exp_coll = -1; exp_irq = 1; end
      1:    begin exp_sda = -1; exp_done = -1; exp_coll = 1; exp_irq = 1; end
      2, 3: begin exp_sda = -1; exp_done = -1; exp_coll = 1; exp_irq = 0; end
      4:    begin exp_sda = -1; exp_done = -1; exp_coll = line_effect_at(inj);
                  exp_irq = 0; end
      default: begin exp_sda = line_effect_at(inj);
                  exp_done = line_effect_at(inj) + e; exp_coll = -1; exp_irq = 1; end
    endcase
    check(sda_n == exp_sda, (sc == 5) ? "R7 early sda" : "R5 sda time", sda_n, exp_sda);
    check(done_n == exp_done, (sc == 6) ? "R8 done time" : "R5 done time", done_n, exp_done);
    check(coll_n == exp_coll, (sc == 4) ? "R6 collision" : "R3 collision", coll_n, exp_coll);
    check(int'(irq_flag) == exp_irq, "R4 irq", irq_flag, exp_irq);
    check(!busy && !sda_oe && !start_en, "R9 release", {busy, sda_oe, start_en}, 0);
    ext_sda_low = 1'b0;
    ext_scl_low = 1'b0;
    repeat (3) @(negedge clk);
    // R10: flags held until cleared
    check(int'(irq_flag) == exp_irq, "R10 irq sticky", irq_flag, exp_irq);
    clr_irq = 1'b1; clr_coll = 1'b1;
    @(negedge clk);
    clr_irq = 1'b0; clr_coll = 1'b0;
    check(!irq_flag && !bus_coll, "R10 clear", {irq_flag, bus_coll}, 0);
  endtask

  initial begin
    void'($urandom(32'h1DC0_5EED));
    repeat (3) @(negedge clk);
    // R1: reset state
    check({sda_oe, scl_oe, start_en, busy, start_done, bus_coll, irq_flag} == 0,
          "R1 reset", {sda_oe, scl_oe, start_en, busy, start_done, bus_coll, irq_flag}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed corners
    run_trial(0, 7'd0, 0);    // R5 zero reload acts as one cycle
    run_trial(0, 7'd1, 0);
    run_trial(1, 7'd5, 0);    // R4 SDA low, SCL high
    run_trial(2, 7'd5, 0);
    run_trial(3, 7'd5, 0);
    run_trial(4, 7'd10, 2);   // R6
    run_trial(5, 7'd10, 8);   // R7 change lands on the last first-count cycle
    run_trial(6, 7'd4, 6);    // R8

    // R10: clear in the same cycle as the collision set
    ext_sda_low = 1'b1;
    repeat (4) @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    clr_coll = 1'b1; clr_irq = 1'b1;
    @(negedge clk);
    clr_coll = 1'b0; clr_irq = 1'b0;
    check(bus_coll && irq_flag, "R10 set wins", {bus_coll, irq_flag}, 3);
    ext_sda_low = 1'b0;
    clr_coll = 1'b1; clr_irq = 1'b1;
    @(negedge clk);
    clr_coll = 1'b0; clr_irq = 1'b0;
    check(!bus_coll && !irq_flag, "R10 clear alone", {bus_coll, irq_flag}, 0);

    // Constrained random trials
    for (int t = 0; t < 60; t++) begin
      int sc = int'($urandom_range(0, 6));
      logic [6:0] r;
      int inj = 0;
      if (sc == 4 || sc == 5) begin
        r = 7'($urandom_range(8, 40));
        inj = int'($urandom_range(2, eff_of(r) - 2));
      end else begin
        r = 7'($urandom_range(0, 127));
        if (sc == 6) inj = eff_of(r) + 2;
      end
      run_trial(sc, r, inj);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule